// File: doc/BRIEF.md
# Four-Queue Write-Side Flag Controller

This block sits on the write side of a buffer controller that holds four queues. A write-clock edge with the address-enable high picks the active queue from a write address. The upper address bits name a device and the low two bits name the queue. A device whose strapped identity matches the device field takes ownership of the shared full line. Any other device gives the line up. Writes go to the owned queue while the active-low write enable is low. A per-queue decrement input stands in for the read side. The per-queue counts are the only model of the storage.

Each queue has an almost-full flag of its own. The full flag covers only the active queue. It is an active-low "not full" signal, driven onto a line that up to eight devices share through three-state outputs. The almost-full offset is taken from a strap while reset is held. A low strap gives an offset of 8 and a high strap gives 128. The offset then stays fixed until the next reset.

Top module: `mqw_flag_top`

## Requirements
- R1: While reset is held and on the first cycle after it, the device does not drive the full line, and all four almost-full flags read 0. All counts start at zero. Reset is synchronous and active low.
- R2: At a clock edge with `sel_en_i` high, the device takes ownership if `sel_addr_i[DEV_W+1:2]` equals `dev_id_i`, and the active queue becomes `sel_addr_i[1:0]`. If the field does not match, the device releases ownership. When `sel_en_i` is low, ownership and the active queue are held.
- R3: The full line shows the state of a newly selected queue from the clock cycle that follows the selecting edge. The level is 1 when the queue is not full and 0 when it holds DEPTH entries. Before that edge, the line still shows the previous queue.
- R4: At an edge with `wr_n_i` low and the device owning a queue that is not full, the active queue's count goes up by one. A write at the same edge as a selection goes to the queue that was active before that edge.
- R5: A write to a full queue is ignored. The count stays at DEPTH and the line stays 0. One decrement afterwards makes the line read 1.
- R6: A high `rd_dec_i[k]` lowers the count of queue k by one. It is ignored when the count is zero. A write and a decrement to the same queue at the same edge leave its count unchanged.
- R7: `afull_o[k]` is 1 exactly when the count of queue k is at least DEPTH minus the offset. The flag is updated in the cycle after the edge that changes the count.
- R8: The offset is 8 if `ofs_strap_i` is low during reset, and 128 if it is high.
- R9: The full line is driven only while the device owns a queue, and `full_drv_o` shows this. Otherwise the output is high impedance, so at most one device drives a line shared with others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ofs_strap_i | input | 1 | Offset strap, sampled during reset (0: 8, 1: 128) |
| dev_id_i | input | DEV_W | Strapped device identity |
| sel_en_i | input | 1 | Address enable for queue selection |
| sel_addr_i | input | DEV_W+2 | Device field above a two-bit queue field |
| wr_n_i | input | 1 | Active-low write enable |
| rd_dec_i | input | 4 | Per-queue count decrement |
| full_n_o | output | 1 | Not-full flag of the active queue, three-state |
| full_drv_o | output | 1 | High while this device drives the full line |
| afull_o | output | 4 | Per-queue almost-full flags |

## Verification
Every result is due one clock after the edge that causes it. This holds for a change of ownership, a switch of the active queue on the full line, a count change seen on the full or almost-full flags, and the offset loaded during reset. The bench drives inputs on the falling edge. It updates its own count and ownership model at the rising edge from the inputs it just applied, and compares every output at the next falling edge, so each check lands exactly one edge after its stimulus. Two devices share one full line. Directed steps check the level just before and just after a queue switch, show the gap between a full queue and an empty one, and sit at both almost-full thresholds.

// File: rtl/mqw_pkg.sv
package mqw_pkg;
    localparam int NUM_Q  = 4;
    localparam int QSEL_W = 2;

    typedef logic [QSEL_W-1:0] qidx_t;

    typedef struct packed {
        logic  own;
        qidx_t q;
    } sel_state_t;
endpackage

// File: rtl/mqw_sel_reg.sv
module mqw_sel_reg
    import mqw_pkg::*;
#(
    parameter int DEV_W = 3,
    localparam int ADDR_W = DEV_W + QSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  dev_id_i,
    input  logic              sel_en_i,
    input  logic [ADDR_W-1:0] sel_addr_i,
    output logic              own_o,
    output qidx_t             sel_o
);
    sel_state_t st_d, st_q;
    logic       id_hit;

    always_comb begin
        id_hit = (sel_addr_i[ADDR_W-1:QSEL_W] == dev_id_i);
        st_d   = st_q;
        if (sel_en_i) begin
            st_d.own = id_hit;
            if (id_hit) st_d.q = sel_addr_i[QSEL_W-1:0];
        end
        if (!rst_n) st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign own_o = st_q.own;
    assign sel_o = st_q.q;

    p_take_queue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_en_i && id_hit |=> own_o && sel_o == $past(sel_addr_i[QSEL_W-1:0]));
    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_en_i && !id_hit |=> !own_o);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_en_i |=> $stable(own_o) && $stable(sel_o));
endmodule

// File: rtl/mqw_offset_reg.sv
module mqw_offset_reg #(
    parameter int DEPTH  = 256,
    parameter int OFF_LO = 8,
    parameter int OFF_HI = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_i,
    output logic [CNT_W-1:0] thresh_o
);
    localparam logic [CNT_W-1:0] TH_LO = CNT_W'(DEPTH - OFF_LO);
    localparam logic [CNT_W-1:0] TH_HI = CNT_W'(DEPTH - OFF_HI);

    typedef struct packed {
        logic             hi;
        logic [CNT_W-1:0] thresh;
    } ofs_state_t;

    ofs_state_t st_d, st_q;

    initial begin
        assert (DEPTH > OFF_HI && DEPTH > OFF_LO && OFF_LO > 0)
            else $error("offsets must lie inside the queue depth");
    end

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.hi     = strap_i;
            st_d.thresh = strap_i ? TH_HI : TH_LO;
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign thresh_o = st_q.thresh;

    p_offset_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(thresh_o));
    p_offset_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        thresh_o == TH_LO || thresh_o == TH_HI);
endmodule

// File: rtl/mqw_q_counter.sv
module mqw_q_counter #(
    parameter int DEPTH = 256,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic             full_o,
    output logic             afull_o
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             full;
        logic             afull;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       inc_ok, dec_ok;

    always_comb begin
        inc_ok = inc_i && !st_q.full;
        dec_ok = dec_i && (st_q.cnt != '0);
        st_d   = st_q;
        if (inc_ok && !dec_ok)      st_d.cnt = st_q.cnt + CNT_W'(1);
        else if (dec_ok && !inc_ok) st_d.cnt = st_q.cnt - CNT_W'(1);
        st_d.full  = (st_d.cnt == TOP);
        st_d.afull = (st_d.cnt >= thresh_i);
        if (!rst_n) st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign full_o  = st_q.full;
    assign afull_o = st_q.afull;

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= TOP);
    p_full_write_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i && full_o && !dec_i |=> $stable(st_q.cnt) && full_o);
    p_count_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i && !full_o && !dec_i |=> st_q.cnt == $past(st_q.cnt) + CNT_W'(1));
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i && !inc_i && st_q.cnt == '0 |=> st_q.cnt == '0);
    p_balanced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i && inc_i && !full_o && st_q.cnt != '0 |=> $stable(st_q.cnt));
    p_afull_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        afull_o |-> st_q.cnt >= thresh_i);
endmodule

// File: rtl/mqw_flag_top.sv
module mqw_flag_top
    import mqw_pkg::*;
#(
    parameter int DEV_W  = 3,
    parameter int DEPTH  = 256,
    parameter int OFF_LO = 8,
    parameter int OFF_HI = 128,
    localparam int ADDR_W = DEV_W + QSEL_W,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ofs_strap_i,
    input  logic [DEV_W-1:0]  dev_id_i,
    input  logic              sel_en_i,
    input  logic [ADDR_W-1:0] sel_addr_i,
    input  logic              wr_n_i,
    input  logic [NUM_Q-1:0]  rd_dec_i,
    output wire               full_n_o,
    output logic              full_drv_o,
    output logic [NUM_Q-1:0]  afull_o
);
    logic             own;
    qidx_t            act_q;
    logic [CNT_W-1:0] thresh;
    logic [NUM_Q-1:0] inc_vec;
    logic [NUM_Q-1:0] full_vec;
    logic             not_full;

    mqw_sel_reg #(.DEV_W(DEV_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_id_i   (dev_id_i),
        .sel_en_i   (sel_en_i),
        .sel_addr_i (sel_addr_i),
        .own_o      (own),
        .sel_o      (act_q)
    );

    mqw_offset_reg #(.DEPTH(DEPTH), .OFF_LO(OFF_LO), .OFF_HI(OFF_HI)) u_ofs (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_i  (ofs_strap_i),
        .thresh_o (thresh)
    );

    for (genvar k = 0; k < NUM_Q; k++) begin : g_q
        assign inc_vec[k] = own && !wr_n_i && (act_q == qidx_t'(k));

        mqw_q_counter #(.DEPTH(DEPTH)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc_i    (inc_vec[k]),
            .dec_i    (rd_dec_i[k]),
            .thresh_i (thresh),
            .full_o   (full_vec[k]),
            .afull_o  (afull_o[k])
        );
    end

    assign not_full   = !full_vec[act_q];
    assign full_drv_o = own;
    assign full_n_o   = own ? not_full : 1'bz;

    p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc_vec));
    p_foreign_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_en_i && sel_addr_i[ADDR_W-1:QSEL_W] != dev_id_i |=> !full_drv_o);
endmodule

// File: tb/mqw_flag_top_tb_top.sv
module mqw_flag_top_tb_top;
    localparam int DEV_W = 3;
    localparam int DEPTH = 256;
    localparam int NQ    = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel_en;
    logic [4:0] sel_addr;
    logic       wr_n;
    logic [3:0] dec_a, dec_b;
    wire        line;
    logic       drv_a, drv_b;
    logic [3:0] af_a, af_b;

    int tests = 0;
    int fails = 0;

    int m_cnt [2][NQ];
    bit m_own [2];
    int m_sel [2];
    int m_th  [2];

    always #10 clk = ~clk;

    mqw_flag_top #(.DEV_W(DEV_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ofs_strap_i(1'b0), .dev_id_i(3'd0),
        .sel_en_i(sel_en), .sel_addr_i(sel_addr), .wr_n_i(wr_n),
        .rd_dec_i(dec_a), .full_n_o(line), .full_drv_o(drv_a), .afull_o(af_a)
    );

    mqw_flag_top #(.DEV_W(DEV_W), .DEPTH(DEPTH)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .ofs_strap_i(1'b1), .dev_id_i(3'd1),
        .sel_en_i(sel_en), .sel_addr_i(sel_addr), .wr_n_i(wr_n),
        .rd_dec_i(dec_b), .full_n_o(line), .full_drv_o(drv_b), .afull_o(af_b)
    );

    function automatic bit exp_af(int i, int q);
        return m_cnt[i][q] >= m_th[i];
    endfunction

    function automatic bit exp_line(int i);
        return m_cnt[i][m_sel[i]] != DEPTH;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        for (int i = 0; i < 2; i++) begin
            logic [3:0] dv;
            int         wq;
            dv = (i == 0) ? dec_a : dec_b;
            if (!rst_n) begin
                m_own[i] = 0;
                m_sel[i] = 0;
                m_th[i]  = DEPTH - ((i == 0) ? 8 : 128);
                for (int q = 0; q < NQ; q++) m_cnt[i][q] = 0;
            end else begin
                wq = (m_own[i] && !wr_n && m_cnt[i][m_sel[i]] != DEPTH) ? m_sel[i] : -1;
                for (int q = 0; q < NQ; q++) begin
                    int nc;
                    nc = m_cnt[i][q];
                    if (wq == q) nc++;
                    if (dv[q] && m_cnt[i][q] > 0) nc--;
                    m_cnt[i][q] = nc;
                end
                if (sel_en) begin
                    m_own[i] = (int'(sel_addr[4:2]) == i);
                    if (m_own[i]) m_sel[i] = int'(sel_addr[1:0]);
                end
            end
        end
    endtask

    task automatic compare();
        chk(drv_a == m_own[0], "R2", "drive A", drv_a, m_own[0]);
        chk(drv_b == m_own[1], "R9", "drive B", drv_b, m_own[1]);
        for (int q = 0; q < NQ; q++) begin
            chk(af_a[q] == exp_af(0, q), "R7", "afull A", af_a[q], exp_af(0, q));
            chk(af_b[q] == exp_af(1, q), "R8", "afull B", af_b[q], exp_af(1, q));
        end
        if (m_own[0]) chk(line == exp_line(0), "R3", "line A", line, exp_line(0));
        if (m_own[1]) chk(line == exp_line(1), "R4", "line B", line, exp_line(1));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        sel_en = 0; wr_n = 1; dec_a = '0; dec_b = '0;
    endtask

    task automatic pick(int dev, int q);
        sel_en   = 1;
        sel_addr = {3'(dev), 2'(q)};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4711);
        rst_n = 0; sel_addr = '0; idle();
        step(); step();
        // R1: nothing driven, flags low during reset
        chk(!drv_a && !drv_b, "R1", "drive in reset", drv_a | drv_b, 0);
        chk(af_a == 0 && af_b == 0, "R1", "afull in reset", af_a | af_b, 0);
        rst_n = 1;
        step();
        chk(!drv_a && !drv_b, "R1", "drive after reset", drv_a | drv_b, 0);

        // R2/R3: device 0 takes queue 2
        pick(0, 2); step(); idle();
        chk(drv_a == 1, "R2", "owner A", drv_a, 1);
        chk(line == 1, "R3", "empty queue line", line, 1);

        // R4/R5: fill queue 2
        wr_n = 0;
        for (int n = 0; n < DEPTH - 8 - 1; n++) step();
        chk(af_a[2] == 0, "R7", "below threshold", af_a[2], 0);
        step();
        chk(af_a[2] == 1, "R7", "at threshold 248", af_a[2], 1);
        for (int n = 0; n < 8; n++) step();
        chk(line == 0, "R4", "full after DEPTH writes", line, 0);
        step(); step();
        chk(line == 0, "R5", "write while full", line, 0);
        wr_n = 1; dec_a = 4'b0100; step(); dec_a = '0;
        chk(line == 1, "R5", "one below full after drop", line, 1);
        wr_n = 0; step(); wr_n = 1;
        chk(line == 0, "R5", "full again", line, 0);

        // R3: switch to empty queue 1, latency of one edge
        pick(0, 1);
        chk(line == 0, "R3", "old queue before edge", line, 0);
        step(); idle();
        chk(line == 1, "R3", "new queue after edge", line, 1);

        // R8/R9: device 1 queue 0, threshold 128
        pick(1, 0); step(); idle();
        chk(drv_a == 0 && drv_b == 1, "R9", "ownership moved", {drv_a, drv_b}, 1);
        wr_n = 0;
        for (int n = 0; n < 127; n++) step();
        chk(af_b[0] == 0, "R8", "127 below 128", af_b[0], 0);
        step();
        chk(af_b[0] == 1, "R8", "128 reaches threshold", af_b[0], 1);

        // R6: write and decrement together keep the count
        dec_b = 4'b0001;
        for (int n = 0; n < 5; n++) step();
        wr_n = 1; step(); dec_b = '0;
        chk(af_b[0] == 0, "R6", "balanced then one drop", af_b[0], 0);
        dec_b = 4'b1000; step(); dec_b = '0;
        chk(af_b[3] == 0, "R6", "empty queue decrement", af_b[3], 0);

        // R4: selection edge write goes to the old queue (queue 0 of device 1)
        pick(1, 3); wr_n = 0; step(); idle();
        chk(af_b[0] == 1, "R4", "write at switch hit old queue", af_b[0], 1);

        // R2/R9: foreign device number, line released
        pick(6, 0); step(); idle();
        chk(!drv_a && !drv_b, "R9", "nobody drives", drv_a | drv_b, 0);

        // random traffic against the model
        for (int n = 0; n < 20000; n++) begin
            int unsigned r;
            r      = $urandom % 8;
            sel_en = ($urandom % 6) == 0;
            sel_addr = {(r < 3) ? 3'd0 : (r < 6) ? 3'd1 : 3'd5, 2'($urandom % 4)};
            wr_n   = ($urandom % 5) == 0;
            for (int q = 0; q < NQ; q++) begin
                dec_a[q] = ($urandom % 40) == 0;
                dec_b[q] = ($urandom % 40) == 0;
            end
            step();
        end
        idle(); step();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule